// File: doc/BRIEF.md
# Mesh Router Output Port Selector

This block decides, for each packet header that reaches a router in a two-dimensional mesh, which of the five router outputs the packet leaves through: the four neighbour directions (west, east, south, north) or the port to the attached processor. It subtracts the router's own coordinates from the header's destination coordinates and looks at the sign of each difference. The offsets carry one extra bit, so every pair of unsigned coordinates gives a correct sign.

A mode input selects one of two policies. In the deterministic policy the x offset is removed completely before any y movement starts. In the partially adaptive policy any westward movement is still made first. Once no westward movement remains, the block may choose among the remaining useful directions, using a per-direction congestion vector to avoid busy outputs. No turn back toward the west is ever taken, which keeps the routes deadlock free.

Each decision is held in an output register with a valid/ready pair on both sides. The result appears one cycle after the header is accepted and stays fixed while the downstream side stalls.

Top module: `mesh_route_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, outValid is 0 and inReady is 1.
- R2: If the destination x is smaller than the router's x, the result is west in both modes, whatever the congestion vector holds. outPort is one-hot: bit 0 local, bit 1 west, bit 2 east, bit 3 south, bit 4 north.
- R3: In deterministic mode (modeAdaptive=0), a destination x larger than the router's x gives east, whatever the y offset is.
- R4: In deterministic mode with equal x, a smaller destination y gives south and a larger destination y gives north.
- R5: When both offsets are zero, the result is the local port in both modes.
- R6: In adaptive mode (modeAdaptive=1) with a non-negative x offset, the candidates are east (x offset positive), north (y offset positive) and south (y offset negative). The first candidate whose congestion bit is 0 is chosen, checking in the order east, north, south. The congestion bits are: bit 0 west, bit 1 east, bit 2 south, bit 3 north.
- R7: In adaptive mode, if every candidate is congested, the first candidate in that order is chosen anyway.
- R8: In deterministic mode the congestion vector has no effect on the result.
- R9: A header accepted at a clock edge (inValid and inReady both 1) produces outValid=1 from that edge on, and outPort is one-hot whenever outValid is 1.
- R10: While outValid=1 and outReady=0, outPort holds its value and inReady is 0. When outReady returns to 1, a waiting header is accepted at the same edge.
- R11: Coordinates are unsigned over their full range. Offsets are formed one bit wider, so the extreme pairs (0 against the maximum) route correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modeAdaptive | input | 1 | 0 selects deterministic x-then-y, 1 selects west-first adaptive |
| myX | input | COORD_W | This router's x coordinate |
| myY | input | COORD_W | This router's y coordinate |
| inValid | input | 1 | Header present |
| inReady | output | 1 | Header can be taken |
| dstX | input | COORD_W | Destination x coordinate |
| dstY | input | COORD_W | Destination y coordinate |
| congest | input | 4 | Busy flags: bit 0 west, 1 east, 2 south, 3 north |
| outValid | output | 1 | Decision present |
| outReady | input | 1 | Downstream takes the decision |
| outPort | output | 5 | One-hot chosen output port |

## Verification
Every decision is due in the cycle after its accepting edge. The bench drives a header at a falling edge, lets one rising edge accept it, and reads outValid and outPort at the next falling edge. Mode, coordinates and congestion are all sampled at that same accepting edge, so each check compares against a value computed from the inputs applied half a cycle before that edge. For the stall case, the bench holds outReady low across several edges and confirms at each falling edge that the earlier result has not changed and that inReady stays low. It then releases outReady and checks the new header one edge later.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;
  localparam int NUM_PORTS = 5;
  localparam int NUM_DIRS  = 4;
  // one-hot bit positions of the output port
  localparam int PORT_LOCAL = 0;
  localparam int PORT_WEST  = 1;
  localparam int PORT_EAST  = 2;
  localparam int PORT_SOUTH = 3;
  localparam int PORT_NORTH = 4;

  typedef logic [NUM_PORTS-1:0] portVec_t;

  typedef struct packed {
    logic load;   // capture a new decision
    logic drain;  // current decision consumed, nothing new
  } routeStrobe_t;
endpackage

// File: rtl/mesh_route_dp.sv
module mesh_route_dp
  import mesh_route_pkg::*;
#(
  parameter int COORD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  routeStrobe_t       strobe,
  input  logic               modeAdaptive,
  input  logic [COORD_W-1:0] myX,
  input  logic [COORD_W-1:0] myY,
  input  logic [COORD_W-1:0] dstX,
  input  logic [COORD_W-1:0] dstY,
  input  logic [NUM_DIRS-1:0] congest,
  output portVec_t           outPort
);
  localparam int OFF_W = COORD_W + 1;

  logic signed [OFF_W-1:0] offX;
  logic signed [OFF_W-1:0] offY;
  logic xNeg, xPos, yNeg, yPos, atDest;
  portVec_t xyPort, wfPort, nextPort;
  portVec_t cand, busy, freeCand;

  // offsets carry one extra sign bit
  assign offX = $signed({1'b0, dstX}) - $signed({1'b0, myX});
  assign offY = $signed({1'b0, dstY}) - $signed({1'b0, myY});

  assign xNeg   = offX < 0;
  assign xPos   = offX > 0;
  assign yNeg   = offY < 0;
  assign yPos   = offY > 0;
  assign atDest = !xNeg && !xPos && !yNeg && !yPos;

  function automatic portVec_t onlyPort(input int idx);
    portVec_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  // fixed order among productive non-west directions: east, north, south
  function automatic portVec_t pickFirst(input portVec_t v);
    if (v[PORT_EAST])       return onlyPort(PORT_EAST);
    else if (v[PORT_NORTH]) return onlyPort(PORT_NORTH);
    else if (v[PORT_SOUTH]) return onlyPort(PORT_SOUTH);
    else                    return onlyPort(PORT_LOCAL);
  endfunction

  // deterministic: finish x, then y
  always_comb begin
    if (xNeg)      xyPort = onlyPort(PORT_WEST);
    else if (xPos) xyPort = onlyPort(PORT_EAST);
    else if (yNeg) xyPort = onlyPort(PORT_SOUTH);
    else if (yPos) xyPort = onlyPort(PORT_NORTH);
    else           xyPort = onlyPort(PORT_LOCAL);
  end

  // congestion flags aligned to the port vector (local never busy)
  assign busy = {congest, 1'b0};

  always_comb begin
    cand             = '0;
    cand[PORT_EAST]  = xPos;
    cand[PORT_NORTH] = !xNeg && yPos;
    cand[PORT_SOUTH] = !xNeg && yNeg;
    freeCand         = cand & ~busy;
    if (xNeg)               wfPort = onlyPort(PORT_WEST);
    else if (atDest)        wfPort = onlyPort(PORT_LOCAL);
    else if (freeCand != 0) wfPort = pickFirst(freeCand);
    else                    wfPort = pickFirst(cand);
  end

  assign nextPort = modeAdaptive ? wfPort : xyPort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           outPort <= '0;
    else if (strobe.load) outPort <= nextPort;
  end
endmodule

// File: rtl/mesh_route_ctrl.sv
module mesh_route_ctrl
  import mesh_route_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  output logic         inReady,
  output logic         outValid,
  input  logic         outReady,
  output routeStrobe_t strobe
);
  assign inReady      = !outValid || outReady;
  assign strobe.load  = inValid && inReady;
  assign strobe.drain = outValid && outReady && !strobe.load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            outValid <= 1'b0;
    else if (strobe.load)  outValid <= 1'b1;
    else if (strobe.drain) outValid <= 1'b0;
  end
endmodule

// File: rtl/mesh_route_unit.sv
module mesh_route_unit
  import mesh_route_pkg::*;
#(
  parameter int COORD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               modeAdaptive,
  input  logic [COORD_W-1:0] myX,
  input  logic [COORD_W-1:0] myY,
  input  logic               inValid,
  output logic               inReady,
  input  logic [COORD_W-1:0] dstX,
  input  logic [COORD_W-1:0] dstY,
  input  logic [3:0]         congest,
  output logic               outValid,
  input  logic               outReady,
  output logic [4:0]         outPort
);
  routeStrobe_t strobe;

  mesh_route_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .strobe(strobe)
  );

  mesh_route_dp #(.COORD_W(COORD_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .modeAdaptive(modeAdaptive),
    .myX(myX), .myY(myY), .dstX(dstX), .dstY(dstY), .congest(congest),
    .outPort(outPort)
  );
endmodule

// File: rtl/mesh_route_unit_chk.sv
module mesh_route_unit_chk #(
  parameter int COORD_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               modeAdaptive,
  input logic [COORD_W-1:0] myX,
  input logic [COORD_W-1:0] myY,
  input logic               inValid,
  input logic               inReady,
  input logic [COORD_W-1:0] dstX,
  input logic [COORD_W-1:0] dstY,
  input logic [3:0]         congest,
  input logic               outValid,
  input logic               outReady,
  input logic [4:0]         outPort
);
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !outValid);

  p_accept_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> outValid);

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $onehot(outPort));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outPort)));

  p_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |-> !inReady);

  p_west_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady && (dstX < myX)) |=> outPort[1]);

  p_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady && (dstX == myX) && (dstY == myY)) |=> outPort[0]);

  p_no_west_turn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady && (dstX >= myX)) |=> !outPort[1]);
endmodule

bind mesh_route_unit mesh_route_unit_chk #(.COORD_W(COORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .modeAdaptive(modeAdaptive), .myX(myX), .myY(myY),
  .inValid(inValid), .inReady(inReady), .dstX(dstX), .dstY(dstY),
  .congest(congest), .outValid(outValid), .outReady(outReady), .outPort(outPort)
);

// File: tb/mesh_route_unit_bench.sv
module mesh_route_unit_bench;
  localparam int CW = 4;
  localparam logic [4:0] L = 5'b00001, W = 5'b00010, E = 5'b00100,
                         S = 5'b01000, N = 5'b10000;

  logic clk = 0, rst_n = 0, modeAdaptive = 0, inValid = 0, outReady = 0;
  logic [CW-1:0] myX = 0, myY = 0, dstX = 0, dstY = 0;
  logic [3:0] congest = 0;
  logic inReady, outValid;
  logic [4:0] outPort;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mesh_route_unit #(.COORD_W(CW)) u_mesh_route_unit (
    .clk(clk), .rst_n(rst_n), .modeAdaptive(modeAdaptive), .myX(myX), .myY(myY),
    .inValid(inValid), .inReady(inReady), .dstX(dstX), .dstY(dstY),
    .congest(congest), .outValid(outValid), .outReady(outReady), .outPort(outPort)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic sendOne(string req, int mx, int my, int dx, int dy,
                         logic mode, logic [3:0] cg, logic [4:0] exp);
    @(negedge clk);
    myX = mx[CW-1:0]; myY = my[CW-1:0]; dstX = dx[CW-1:0]; dstY = dy[CW-1:0];
    modeAdaptive = mode; congest = cg; inValid = 1; outReady = 1;
    @(negedge clk);
    inValid = 0;
    check({req, " valid"}, {31'b0, outValid}, 1);
    check(req, {27'b0, outPort}, {27'b0, exp});
  endtask

  task automatic testReset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    check("R1 valid in reset", {31'b0, outValid}, 0);
    check("R1 ready in reset", {31'b0, inReady}, 1);
    rst_n = 1;
    @(negedge clk);
    check("R1 valid after reset", {31'b0, outValid}, 0);
  endtask

  task automatic testDeterministic();
    sendOne("R2 xy west", 5, 5, 2, 9, 0, 4'b0000, W);
    sendOne("R3 xy east", 5, 5, 9, 1, 0, 4'b0000, E);
    sendOne("R4 xy south", 5, 5, 5, 1, 0, 4'b0000, S);
    sendOne("R4 xy north", 5, 5, 5, 12, 0, 4'b0000, N);
    sendOne("R5 xy local", 5, 5, 5, 5, 0, 4'b0000, L);
  endtask

  task automatic testAdaptive();
    sendOne("R6 wf east free", 5, 5, 9, 9, 1, 4'b0000, E);
    sendOne("R6 wf east busy north", 5, 5, 9, 9, 1, 4'b0010, N);
    sendOne("R6 wf east busy south", 5, 5, 9, 1, 1, 4'b0010, S);
    sendOne("R6 wf only north", 5, 5, 5, 9, 1, 4'b0010, N);
    sendOne("R7 wf all busy ne", 5, 5, 9, 9, 1, 4'b1010, E);
    sendOne("R7 wf all busy es", 5, 5, 9, 1, 1, 4'b0110, E);
    sendOne("R7 wf only north busy", 5, 5, 5, 9, 1, 4'b1000, N);
    sendOne("R2 wf west busy", 5, 5, 2, 9, 1, 4'b1111, W);
    sendOne("R5 wf local", 5, 5, 5, 5, 1, 4'b1111, L);
  endtask

  task automatic testCongestIgnored();
    sendOne("R8 xy east all busy", 5, 5, 9, 9, 0, 4'b1111, E);
    sendOne("R8 xy south all busy", 5, 5, 5, 1, 0, 4'b1111, S);
  endtask

  task automatic testFullRange();
    sendOne("R11 min to max", 0, 0, 15, 15, 0, 4'b0000, E);
    sendOne("R11 max to min", 15, 15, 0, 0, 0, 4'b0000, W);
    sendOne("R11 y max", 15, 0, 15, 15, 0, 4'b0000, N);
    sendOne("R11 wf y min", 15, 15, 15, 0, 1, 4'b0000, S);
  endtask

  task automatic testBackpressure();
    @(negedge clk);
    myX = 5; myY = 5; dstX = 9; dstY = 5; modeAdaptive = 0; congest = 0;
    inValid = 1; outReady = 0;
    @(negedge clk);
    check("R9 stall first valid", {31'b0, outValid}, 1);
    check("R9 stall first port", {27'b0, outPort}, {27'b0, E});
    dstX = 1;  // new waiting header: would be west
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 held port", {27'b0, outPort}, {27'b0, E});
      check("R10 ready low", {31'b0, inReady}, 0);
    end
    outReady = 1;
    @(negedge clk);
    inValid = 0;
    check("R10 release valid", {31'b0, outValid}, 1);
    check("R10 release new port", {27'b0, outPort}, {27'b0, W});
    @(negedge clk);
    check("R9 drained", {31'b0, outValid}, 0);
  endtask

  initial begin
    testReset();
    testDeterministic();
    testAdaptive();
    testCongestIgnored();
    testFullRange();
    testBackpressure();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule